// File: doc/BRIEF.md
# CVSD Delta Modulation Codec Core

This block is an all-digital, full-duplex continuously variable slope delta (CVSD) codec. The transmit lane takes a signed PCM sample on each encoder tick. It compares the sample with a locally rebuilt estimate and sends out a single bit. The receive lane takes one bit on each decoder tick and rebuilds a signed PCM sample from it. Both lanes share the same adaptation law. A run detector looks for a string of equal bits, three or four long as chosen by a pin. That detector drives a slowly moving slope (step) register. The slope then feeds a leaky, saturating integrator that holds the estimate.

Each lane has an active-low hush input. When hush is low, the lane replaces its live bit with a strict alternating pattern, so the lane's estimate settles around zero. A transmit-enable input and an active-high awake input together decide whether the transmit bit is driven, released to high impedance, or held low. The high-impedance case is shown as an output-enable pin. When awake is low, both lanes freeze. Tick strobes are clock enables on one system clock. The analogue filtering and the conversion to and from analogue signals sit outside this block.

Top module: `cvsd_codec`

## Requirements
- R1: After reset both estimates are 0, the transmit bit register is 0, both slopes are at their minimum (32), the run history holds the non-coincident pattern 0101 (newest bit in bit 0), and both alternating-pattern phases are 0.
- R2: On an encoder tick with hush high, the transmit bit is 1 when the input sample is greater than or equal to the transmit estimate, and 0 otherwise. The bit appears on `enc_data_o` at the clock edge that samples the tick.
- R3: On each decoder tick the receive estimate moves up by the current slope for a 1 and down for a 0, after the leak. `dec_pcm_o` shows the updated estimate from the clock edge that samples the tick.
- R4: `run3_i` = 1 declares coincidence when the newest 3 lane bits (the current bit included) are all equal. `run3_i` = 0 requires the newest 4 to be equal.
- R5: The slope lies in [32, 1600]. On coincidence it rises by max(1, (1600 − slope) >> 7). Otherwise it falls by max(1, (slope − 32) >> 7). The integrator update uses the slope held before this move.
- R6: The estimate clamps at +32767 and −32768 and never wraps.
- R7: Each tick, before the slope is added, the estimate loses |estimate| >> 5 toward zero.
- R8: With `enc_hush_ni` low, the transmit bits alternate 0,1,0,1,… whatever the sample. The first is 0 after reset. The phase advances only on hushed ticks, and the local estimate tracks the bits sent.
- R9: With `dec_hush_ni` low, `dec_data_i` is ignored and an alternating pattern drives the receive lane, so its output settles within ±128 of zero.
- R10: With `awake_i` = 1, `enc_oe_o` equals `tx_en_i` and `enc_data_o` carries the transmit bit. With `awake_i` = 0, `enc_oe_o` = 1 and `enc_data_o` = 0.
- R11: While `awake_i` is 0, ticks are ignored and all lane state holds. Operation resumes from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| awake_i | input | 1 | 1 = operating, 0 = quiescent |
| run3_i | input | 1 | 1 = three-bit run, 0 = four-bit run |
| enc_tick_i | input | 1 | Transmit sample strobe |
| enc_pcm_i | input | 16 | Signed PCM sample to encode |
| enc_hush_ni | input | 1 | Active-low transmit force-idle |
| tx_en_i | input | 1 | Transmit output enable |
| enc_data_o | output | 1 | Transmit bit |
| enc_oe_o | output | 1 | Drive enable for the transmit bit (0 = high impedance) |
| dec_tick_i | input | 1 | Receive bit strobe |
| dec_data_i | input | 1 | Received bit |
| dec_hush_ni | input | 1 | Active-low receive force-idle |
| dec_pcm_o | output | 16 | Signed rebuilt PCM sample |

## Verification
A wrong slope or run history does not show at once. It appears a few ticks later as an estimate that climbs at the wrong rate, so the transmit bit stream or `dec_pcm_o` departs from an independent model within the next few samples after the first disagreement. A wrong leak or clamp is clearest at full scale: the first tick after saturation shows an exact value (30144 after a single 0 bit), and a wrap would show as a jump of tens of thousands. Errors in the hush phase or in the freeze show on the very next tick, as a repeated bit or as an output that moves while the block is asleep.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

  localparam int LANE_ENC = 0;
  localparam int LANE_DEC = 1;
  localparam int N_LANES  = 2;

  typedef enum logic {
    RUN_FOUR  = 1'b0,
    RUN_THREE = 1'b1
  } run_len_e;

  localparam logic [3:0] HIST_RESET = 4'b0101;

  function automatic logic run_coincident(input logic [3:0] hist, input run_len_e sel);
    logic all3;
    logic all4;
    all3 = (hist[2:0] == 3'b000) || (hist[2:0] == 3'b111);
    all4 = (hist == 4'b0000) || (hist == 4'b1111);
    return (sel == RUN_THREE) ? all3 : all4;
  endfunction

endpackage

// File: rtl/cvsd_step_adapt.sv
module cvsd_step_adapt #(
  parameter int SW       = 11,
  parameter int STEP_MIN = 32,
  parameter int STEP_MAX = 1600,
  parameter int STEP_SH  = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          bit_i,
  input  logic          run3_i,
  output logic [SW-1:0] step_o
);
  import cvsd_pkg::*;

  localparam logic [SW-1:0] LO = SW'(STEP_MIN);
  localparam logic [SW-1:0] HI = SW'(STEP_MAX);

  logic [3:0]    hist_q, hist_d;
  logic [SW-1:0] step_q, step_d;
  logic [SW-1:0] gap, amt;
  logic          coin;
  run_len_e      sel;

  assign sel = run_len_e'(run3_i);

  always_comb begin
    hist_d = hist_q;
    step_d = step_q;
    gap    = '0;
    amt    = '0;
    coin   = 1'b0;
    if (upd_i) begin
      hist_d = {hist_q[2:0], bit_i};
      coin   = run_coincident(hist_d, sel);
      if (coin) begin
        gap = HI - step_q;
        amt = gap >> STEP_SH;
        if ((amt == '0) && (gap != '0)) amt = SW'(1);
        step_d = step_q + amt;
      end else begin
        gap = step_q - LO;
        amt = gap >> STEP_SH;
        if ((amt == '0) && (gap != '0)) amt = SW'(1);
        step_d = step_q - amt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= HIST_RESET;
      step_q <= LO;
    end else if (upd_i) begin
      hist_q <= hist_d;
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/cvsd_leaky_integ.sv
module cvsd_leaky_integ #(
  parameter int W       = 16,
  parameter int SW      = 11,
  parameter int LEAK_SH = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic          bit_i,
  input  logic [SW-1:0] step_i,
  output logic [W-1:0]  est_o
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] TOP = XW'((2 ** (W - 1)) - 1);
  localparam logic signed [XW-1:0] BOT = -TOP - XW'(1);

  logic [W-1:0]           est_q, est_d;
  logic signed [XW-1:0]   ext, mag, drain, slope, total;

  always_comb begin
    ext   = signed'({{2{est_q[W-1]}}, est_q});
    mag   = ext[XW-1] ? -ext : ext;
    drain = mag >>> LEAK_SH;
    if (ext[XW-1]) drain = -drain;
    slope = signed'(XW'(step_i));
    total = ext - drain + (bit_i ? slope : -slope);
    est_d = est_q;
    if (upd_i) begin
      if (total > TOP)      est_d = TOP[W-1:0];
      else if (total < BOT) est_d = BOT[W-1:0];
      else                  est_d = total[W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    est_q <= '0;
    else if (upd_i) est_q <= est_d;
  end

  assign est_o = est_q;

endmodule

// File: rtl/cvsd_lane.sv
module cvsd_lane #(
  parameter bit ENCODE   = 1'b1,
  parameter int W        = 16,
  parameter int SW       = 11,
  parameter int STEP_MIN = 32,
  parameter int STEP_MAX = 1600,
  parameter int STEP_SH  = 7,
  parameter int LEAK_SH  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hush_ni,
  input  logic          run3_i,
  input  logic [W-1:0]  pcm_i,
  input  logic          bit_i,
  output logic          bit_o,
  output logic [W-1:0]  est_o,
  output logic [SW-1:0] step_o
);
  logic          phase_q, phase_d;
  logic          bit_q, bit_d;
  logic          cmp, live, chosen;
  logic [W-1:0]  est;
  logic [SW-1:0] step;

  always_comb begin
    cmp     = $signed(pcm_i) >= $signed(est);
    live    = ENCODE ? cmp : bit_i;
    chosen  = hush_ni ? live : phase_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    if (tick_i) begin
      bit_d = chosen;
      if (!hush_ni) phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      bit_q   <= 1'b0;
    end else if (tick_i) begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
    end
  end

  cvsd_step_adapt #(
    .SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_SH(STEP_SH)
  ) u_adapt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (tick_i),
    .bit_i (chosen),
    .run3_i(run3_i),
    .step_o(step)
  );

  cvsd_leaky_integ #(
    .W(W), .SW(SW), .LEAK_SH(LEAK_SH)
  ) u_integ (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (tick_i),
    .bit_i (chosen),
    .step_i(step),
    .est_o (est)
  );

  assign bit_o  = bit_q;
  assign est_o  = est;
  assign step_o = step;

endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec #(
  parameter int PCM_W    = 16,
  parameter int STEP_MIN = 32,
  parameter int STEP_MAX = 1600,
  parameter int STEP_SH  = 7,
  parameter int LEAK_SH  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             awake_i,
  input  logic             run3_i,
  input  logic             enc_tick_i,
  input  logic [PCM_W-1:0] enc_pcm_i,
  input  logic             enc_hush_ni,
  input  logic             tx_en_i,
  output logic             enc_data_o,
  output logic             enc_oe_o,
  input  logic             dec_tick_i,
  input  logic             dec_data_i,
  input  logic             dec_hush_ni,
  output logic [PCM_W-1:0] dec_pcm_o
);
  import cvsd_pkg::*;

  localparam int SW = $clog2(STEP_MAX + 1);

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [N_LANES-1:0] lane_tick, lane_hush_n, lane_bit_in, lane_bit;
  logic [PCM_W-1:0]   lane_pcm  [N_LANES];
  logic [PCM_W-1:0]   lane_est  [N_LANES];
  logic [SW-1:0]      lane_step [N_LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign lane_tick   = {dec_tick_i, enc_tick_i} & {N_LANES{awake_i & rst_sync_n}};
  assign lane_hush_n = {dec_hush_ni, enc_hush_ni};
  assign lane_bit_in = {dec_data_i, 1'b0};
  assign lane_pcm[LANE_ENC] = enc_pcm_i;
  assign lane_pcm[LANE_DEC] = '0;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    cvsd_lane #(
      .ENCODE  (g == LANE_ENC),
      .W       (PCM_W),
      .SW      (SW),
      .STEP_MIN(STEP_MIN),
      .STEP_MAX(STEP_MAX),
      .STEP_SH (STEP_SH),
      .LEAK_SH (LEAK_SH)
    ) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .tick_i (lane_tick[g]),
      .hush_ni(lane_hush_n[g]),
      .run3_i (run3_i),
      .pcm_i  (lane_pcm[g]),
      .bit_i  (lane_bit_in[g]),
      .bit_o  (lane_bit[g]),
      .est_o  (lane_est[g]),
      .step_o (lane_step[g])
    );
  end

  assign enc_data_o = awake_i & lane_bit[LANE_ENC];
  assign enc_oe_o   = ~awake_i | tx_en_i;
  assign dec_pcm_o  = lane_est[LANE_DEC];

endmodule

// File: rtl/cvsd_codec_chk.sv
module cvsd_codec_chk #(
  parameter int PCM_W    = 16,
  parameter int SW       = 11,
  parameter int STEP_MIN = 32,
  parameter int STEP_MAX = 1600,
  parameter int LEAK_SH  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_sync_n,
  input logic             awake_i,
  input logic             tx_en_i,
  input logic             enc_tick_i,
  input logic             enc_hush_ni,
  input logic             dec_tick_i,
  input logic             dec_hush_ni,
  input logic             enc_data_o,
  input logic             enc_oe_o,
  input logic [PCM_W-1:0] dec_pcm_o,
  input logic [PCM_W-1:0] enc_est,
  input logic             enc_bit,
  input logic             dec_bit,
  input logic [SW-1:0]    enc_step,
  input logic [SW-1:0]    dec_step
);
  localparam int SLEW = STEP_MAX + ((2 ** (PCM_W - 1)) >> LEAK_SH) + 1;

  logic             enc_prev_idle, dec_prev_idle;
  logic [PCM_W-1:0] enc_prev, dec_prev;
  int               enc_delta, dec_delta;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      enc_prev_idle <= 1'b0;
      dec_prev_idle <= 1'b0;
      enc_prev      <= '0;
      dec_prev      <= '0;
    end else begin
      if (enc_tick_i && awake_i) enc_prev_idle <= !enc_hush_ni;
      if (dec_tick_i && awake_i) dec_prev_idle <= !dec_hush_ni;
      enc_prev <= enc_est;
      dec_prev <= dec_pcm_o;
    end
  end

  always_comb begin
    enc_delta = int'($signed(enc_est)) - int'($signed(enc_prev));
    dec_delta = int'($signed(dec_pcm_o)) - int'($signed(dec_prev));
    if (enc_delta < 0) enc_delta = -enc_delta;
    if (dec_delta < 0) dec_delta = -dec_delta;
  end

  assert_drive_table_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!awake_i |-> (enc_oe_o && !enc_data_o)) and (awake_i |-> (enc_oe_o == tx_en_i)));

  assert_step_range_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (enc_step >= SW'(STEP_MIN)) && (enc_step <= SW'(STEP_MAX)) &&
    (dec_step >= SW'(STEP_MIN)) && (dec_step <= SW'(STEP_MAX)));

  assert_freeze_R11: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !awake_i |=> ($stable(dec_pcm_o) && $stable(enc_est) && $stable(enc_step)));

  assert_enc_idle_alt_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (enc_tick_i && awake_i && !enc_hush_ni && enc_prev_idle) |=> (enc_bit != $past(enc_bit)));

  assert_dec_idle_alt_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (dec_tick_i && awake_i && !dec_hush_ni && dec_prev_idle) |=> (dec_bit != $past(dec_bit)));

  assert_bounded_slew_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (enc_delta <= SLEW) && (dec_delta <= SLEW));

endmodule

bind cvsd_codec cvsd_codec_chk #(
  .PCM_W   (PCM_W),
  .SW      (SW),
  .STEP_MIN(STEP_MIN),
  .STEP_MAX(STEP_MAX),
  .LEAK_SH (LEAK_SH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_sync_n (rst_sync_n),
  .awake_i    (awake_i),
  .tx_en_i    (tx_en_i),
  .enc_tick_i (enc_tick_i),
  .enc_hush_ni(enc_hush_ni),
  .dec_tick_i (dec_tick_i),
  .dec_hush_ni(dec_hush_ni),
  .enc_data_o (enc_data_o),
  .enc_oe_o   (enc_oe_o),
  .dec_pcm_o  (dec_pcm_o),
  .enc_est    (lane_est[0]),
  .enc_bit    (lane_bit[0]),
  .dec_bit    (lane_bit[1]),
  .enc_step   (lane_step[0]),
  .dec_step   (lane_step[1])
);

// File: tb/sim_cvsd_codec.sv
module sim_cvsd_codec;
  localparam int CLK_PERIOD = 10;
  localparam int SMIN = 32;
  localparam int SMAX = 1600;
  localparam int SSH  = 7;
  localparam int LSH  = 5;
  localparam int PMAX = 32767;
  localparam int PMIN = -32768;

  logic clk = 1'b0;
  logic rst_n, awake, run3, enc_tick, enc_hush_n, tx_en, dec_tick, dec_bit, dec_hush_n;
  logic [15:0] enc_pcm;
  logic enc_data, enc_oe;
  logic signed [15:0] dec_pcm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_est [2];
  int m_step[2];
  int m_hist[2];
  int m_phase[2];
  bit m_encq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cvsd_codec #(.PCM_W(16), .STEP_MIN(SMIN), .STEP_MAX(SMAX), .STEP_SH(SSH), .LEAK_SH(LSH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .awake_i(awake), .run3_i(run3),
    .enc_tick_i(enc_tick), .enc_pcm_i(enc_pcm), .enc_hush_ni(enc_hush_n),
    .tx_en_i(tx_en), .enc_data_o(enc_data), .enc_oe_o(enc_oe),
    .dec_tick_i(dec_tick), .dec_data_i(dec_bit), .dec_hush_ni(dec_hush_n),
    .dec_pcm_o(dec_pcm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Reference model of one lane tick, written from the requirements
  task automatic model_tick(input int ln, input bit raw, input bit hush_n, input bit r3,
                            output bit used);
    int e, lk, sum, h, g, a;
    bit coin;
    used = hush_n ? raw : m_phase[ln][0];
    if (!hush_n) m_phase[ln] = m_phase[ln] ^ 1;
    e  = m_est[ln];
    lk = (e < 0) ? -((-e) >> LSH) : (e >> LSH);
    sum = e - lk + (used ? m_step[ln] : -m_step[ln]);
    if (sum > PMAX) sum = PMAX;
    if (sum < PMIN) sum = PMIN;
    m_est[ln] = sum;
    h = ((m_hist[ln] << 1) | int'(used)) & 15;
    m_hist[ln] = h;
    coin = r3 ? (((h & 7) == 0) || ((h & 7) == 7)) : ((h == 0) || (h == 15));
    if (coin) begin
      g = SMAX - m_step[ln]; a = g >> SSH; if (a == 0 && g != 0) a = 1;
      m_step[ln] = m_step[ln] + a;
    end else begin
      g = m_step[ln] - SMIN; a = g >> SSH; if (a == 0 && g != 0) a = 1;
      m_step[ln] = m_step[ln] - a;
    end
  endtask

  task automatic pulse(input bit de, input int sample, input bit dd, input bit dbit);
    bit b;
    @(negedge clk);
    enc_tick = de; dec_tick = dd; enc_pcm = sample[15:0]; dec_bit = dbit;
    @(negedge clk);
    enc_tick = 1'b0; dec_tick = 1'b0;
    if (awake) begin
      if (de) begin
        model_tick(0, sample >= m_est[0], enc_hush_n, run3, b);
        m_encq = b;
      end
      if (dd) model_tick(1, dbit, dec_hush_n, run3, b);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; awake = 1'b1; run3 = 1'b1; enc_tick = 1'b0; enc_hush_n = 1'b1;
    tx_en = 1'b1; dec_tick = 1'b0; dec_bit = 1'b0; dec_hush_n = 1'b1; enc_pcm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      m_est[i] = 0; m_step[i] = SMIN; m_hist[i] = 5; m_phase[i] = 0;
    end
    m_encq = 1'b0;
  endtask

  task automatic t_reset();
    apply_reset();
    chk(dec_pcm == 0, "R1 dec_pcm after reset", dec_pcm, 0);
    chk(enc_data == 1'b0, "R1 enc_data after reset", enc_data, 0);
    chk(enc_oe == 1'b1, "R1 enc_oe after reset", enc_oe, 1);
  endtask

  task automatic t_encode();
    int s;
    apply_reset();
    pulse(1'b1, 0, 1'b0, 1'b0);
    chk(enc_data == 1'b1, "R2 equal sample gives 1", enc_data, 1);
    pulse(1'b1, -1, 1'b0, 1'b0);
    chk(enc_data == 1'b0, "R2 below estimate gives 0", enc_data, 0);
    for (int i = 0; i < 400; i++) begin
      s = ((i % 100) < 50) ? (i % 100) * 400 : (100 - (i % 100)) * 400;
      s = s - 10000;
      pulse(1'b1, s, 1'b0, 1'b0);
      chk(enc_data == m_encq, "R2 encoder bit stream", enc_data, m_encq);
    end
  endtask

  task automatic t_decode();
    logic [15:0] lf = 16'hACE1;
    apply_reset();
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pulse(1'b0, 0, 1'b1, lf[0]);
      chk(int'(dec_pcm) == m_est[1], "R3 decoder estimate", dec_pcm, m_est[1]);
    end
  endtask

  task automatic t_runlen();
    int pk3 = 0;
    int pk4 = 0;
    int a;
    apply_reset();
    run3 = 1'b1;
    for (int i = 0; i < 120; i++) begin
      pulse(1'b0, 0, 1'b1, (i % 6) < 3);
      chk(int'(dec_pcm) == m_est[1], "R4 three-bit run select", dec_pcm, m_est[1]);
      a = (dec_pcm < 0) ? -int'(dec_pcm) : int'(dec_pcm);
      if (a > pk3) pk3 = a;
    end
    apply_reset();
    run3 = 1'b0;
    for (int i = 0; i < 120; i++) begin
      pulse(1'b0, 0, 1'b1, (i % 6) < 3);
      chk(int'(dec_pcm) == m_est[1], "R4 four-bit run select", dec_pcm, m_est[1]);
      a = (dec_pcm < 0) ? -int'(dec_pcm) : int'(dec_pcm);
      if (a > pk4) pk4 = a;
    end
    chk(pk3 > pk4, "R4 three-run grows slope, four-run does not", pk3, pk4);
    for (int i = 0; i < 64; i++) begin
      pulse(1'b0, 0, 1'b1, (i % 8) < 4);
      chk(int'(dec_pcm) == m_est[1], "R4 four-bit runs coincide", dec_pcm, m_est[1]);
    end
  endtask

  task automatic t_saturate();
    apply_reset();
    for (int i = 0; i < 2500; i++) begin
      pulse(1'b0, 0, 1'b1, 1'b1);
      chk(int'(dec_pcm) == m_est[1], "R5 slope growth", dec_pcm, m_est[1]);
    end
    chk(int'(dec_pcm) == PMAX, "R6 clamp at positive full scale", dec_pcm, PMAX);
    pulse(1'b0, 0, 1'b1, 1'b0);
    chk(int'(dec_pcm) == PMAX - (PMAX >> LSH) - SMAX, "R5 R7 maximum slope and leak",
        dec_pcm, PMAX - (PMAX >> LSH) - SMAX);
    for (int i = 0; i < 2500; i++) begin
      pulse(1'b0, 0, 1'b1, 1'b0);
      chk(int'(dec_pcm) == m_est[1], "R6 descent", dec_pcm, m_est[1]);
    end
    chk(int'(dec_pcm) == PMIN, "R6 clamp at negative full scale", dec_pcm, PMIN);
  endtask

  task automatic t_dec_idle();
    int a;
    dec_hush_n = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      pulse(1'b0, 0, 1'b1, 1'b1);
      chk(int'(dec_pcm) == m_est[1], "R9 alternating pattern replaces bits", dec_pcm, m_est[1]);
      if (i == 300) begin
        a = (dec_pcm < 0) ? -int'(dec_pcm) : int'(dec_pcm);
        chk(a < 16000, "R7 leak pulls toward zero", a, 16000);
      end
    end
    a = (dec_pcm < 0) ? -int'(dec_pcm) : int'(dec_pcm);
    chk(a <= 128, "R9 settles near midscale", a, 128);
    dec_hush_n = 1'b1;
  endtask

  task automatic t_enc_idle();
    apply_reset();
    enc_hush_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      pulse(1'b1, 30000, 1'b0, 1'b0);
      chk(enc_data == bit'(i % 2), "R8 hushed encoder alternates from 0", enc_data, i % 2);
    end
    enc_hush_n = 1'b1;
    pulse(1'b1, 30000, 1'b0, 1'b0);
    chk(enc_data == m_encq, "R8 normal encoding resumes", enc_data, m_encq);
    chk(enc_data == 1'b1, "R2 sample above estimate", enc_data, 1);
  endtask

  task automatic t_drive();
    awake = 1'b1; tx_en = 1'b1; #1;
    chk(enc_oe == 1'b1 && enc_data == 1'b1, "R10 awake enabled drives bit", {enc_oe, enc_data}, 3);
    tx_en = 1'b0; #1;
    chk(enc_oe == 1'b0, "R10 awake disabled releases output", enc_oe, 0);
    awake = 1'b0; tx_en = 1'b1; #1;
    chk(enc_oe == 1'b1 && enc_data == 1'b0, "R10 asleep drives low", {enc_oe, enc_data}, 2);
    tx_en = 1'b0; #1;
    chk(enc_oe == 1'b1 && enc_data == 1'b0, "R10 asleep ignores enable", {enc_oe, enc_data}, 2);
    awake = 1'b1; tx_en = 1'b1;
  endtask

  task automatic t_freeze();
    int held;
    apply_reset();
    for (int i = 0; i < 20; i++) pulse(1'b1, 5000, 1'b1, 1'b1);
    held = int'(dec_pcm);
    awake = 1'b0;
    for (int i = 0; i < 10; i++) begin
      pulse(1'b1, -20000, 1'b1, 1'b0);
      chk(int'(dec_pcm) == held, "R11 decoder held while asleep", dec_pcm, held);
      chk(enc_data == 1'b0, "R11 transmit low while asleep", enc_data, 0);
    end
    awake = 1'b1;
    for (int i = 0; i < 10; i++) begin
      pulse(1'b1, -20000, 1'b1, 1'b0);
      chk(int'(dec_pcm) == m_est[1], "R11 decoder resumes", dec_pcm, m_est[1]);
      chk(enc_data == m_encq, "R11 encoder resumes", enc_data, m_encq);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_encode();
    t_decode();
    t_runlen();
    t_saturate();
    t_dec_idle();
    t_enc_idle();
    t_drive();
    t_freeze();
    finish_run();
  end

endmodule